// File: doc/BRIEF.md
# Secure Boot Verification Sequencer

This block runs once after every reset. It decides whether protected boot code may run, based on a two-bit verification option. Code 0 releases the boot code at once. Code 1 hashes the protected region and checks the result. Codes 2 and 3 do the same, but first feed a 256-bit key into the hash. The sequencer fetches words over a read-only memory port. It streams them to an external hash engine over a valid/ready handshake, waits for the engine's done pulse, and compares the returned 256-bit digest with a reference held in the last eight words of the region.

A matching digest releases the boot code. A mismatch latches a failure that holds the device in reset. Warm resets cannot clear this failure; only a full-erase command or a power-on reset clears it. The full erase also restores factory configuration, which means no verification, so the boot code is released without hashing until the next power-on reset.

Top module: `secure_boot_seq`

## Requirements
- R1: Power-on reset (`por`) clears the failure latch and the factory flag. While it is applied, `busy`=1, `boot_release`=0 and `hold_reset`=0.
- R2: With option code 0, `boot_release` rises one clock edge after `rst` falls. No `hash_start` is issued.
- R3: With option code 1, exactly one single-cycle `hash_start` precedes all data. The streamed data are the region words at word addresses `region_base` to `region_base+region_words-9`, in ascending order. `region_words` counts every word of the region, including the eight reference words.
- R4: With option codes 2 and 3, the key words are streamed before the region data, `auth_key[31:0]` first and `auth_key[255:224]` last.
- R5: A data beat happens only when `hash_valid` and `hash_ready` are both high. While `hash_ready` is low, `hash_valid` and `hash_data` stay unchanged.
- R6: Word j of `hash_digest` (bits 32j+31 to 32j) is compared with the memory word at `region_base+region_words-8+j`. If all eight words match, `boot_release` is high and `busy` low in the cycle after the `hash_done` cycle.
- R7: On any mismatch, in the cycle after `hash_done`, `hold_reset` is high and both `boot_release` and `busy` are low. Release and hold are never high together.
- R8: A latched failure survives `rst`. After a warm reset the sequencer issues no `hash_start`, enables no memory read, and keeps `hold_reset` high with `busy` low.
- R9: `erase_all` while failed clears `hold_reset` one edge later. On the next edge `boot_release` rises. Until the next `por`, later warm resets treat the option as 0.
- R10: `erase_all` has no effect unless the failure is latched. This holds both during verification and after release.
- R11: `busy` is high from reset release until the sequencer enters the release or failure state. `busy` falls only when one of those outcomes becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | Warm reset, synchronous, active high; restarts the sequence |
| boot_opt | input | 2 | Verification option code |
| region_base | input | ADDR_W | Word address of the first region word |
| region_words | input | ADDR_W | Region length in words, including 8 reference words |
| auth_key | input | 256 | Key for keyed modes |
| erase_all | input | 1 | Full-erase command |
| mem_en | output | 1 | Memory read enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rdata | input | 32 | Memory read data, same cycle |
| hash_start | output | 1 | Start pulse to hash engine |
| hash_valid | output | 1 | Data word valid |
| hash_ready | input | 1 | Hash engine accepts a word |
| hash_data | output | 32 | Data word to hash engine |
| hash_done | input | 1 | Hash result ready pulse |
| hash_digest | input | 256 | Hash result |
| boot_release | output | 1 | Boot code may execute |
| hold_reset | output | 1 | Device held in reset loop |
| busy | output | 1 | Verification in progress |

## Verification
The bench drives inputs and samples outputs on falling edges, so each result is checked in a fixed cycle:

- **Option 0:** the release is checked at the first falling edge after `rst` drops.
- **Verdict:** the match or mismatch outcome is checked at the falling edge one cycle after the `hash_done` cycle.
- **Erase:** the hold is checked as cleared one edge after `erase_all`, and the release one edge after that.
- **Streamed words:** each word is compared with the reference queue at the falling edge where the bench raises `hash_ready`, because the beat completes on the following rising edge.
- **Stalls:** in a stalled cycle, the word is compared with the one held in the previous cycle.

// File: rtl/bsv_pkg.sv
package bsv_pkg;
    localparam int WORD_W    = 32;
    localparam int DIG_WORDS = 8;
    localparam int DIG_W     = WORD_W * DIG_WORDS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF,
        ST_START,
        ST_KEY,
        ST_DATA,
        ST_WAIT,
        ST_PASS,
        ST_FAIL
    } seq_state_e;

    function automatic logic opt_checks(input logic [1:0] code);
        return code != 2'd0;
    endfunction

    function automatic logic opt_keyed(input logic [1:0] code);
        return code[1];
    endfunction
endpackage

// File: rtl/bsv_step_counter.sv
module bsv_step_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (clr)      cnt <= '0;
        else if (inc) cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/bsv_ref_bank.sv
module bsv_ref_bank #(
    parameter int NW = 8,
    parameter int WW = 32
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [$clog2(NW)-1:0]  wr_sel,
    input  logic [WW-1:0]          wr_word,
    input  logic [NW*WW-1:0]       digest,
    output logic                   match
);
    localparam int SW = $clog2(NW);
    logic [NW-1:0] eq;

    for (genvar g = 0; g < NW; g++) begin : g_word
        logic [WW-1:0] ref_q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_sel == SW'(g)) ref_q <= wr_word;
        end
        assign eq[g] = (ref_q == digest[g*WW +: WW]);
    end

    assign match = &eq;
endmodule

// File: rtl/secure_boot_seq.sv
module secure_boot_seq
    import bsv_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              por,
    input  logic              rst,
    input  logic [1:0]        boot_opt,
    input  logic [ADDR_W-1:0] region_base,
    input  logic [ADDR_W-1:0] region_words,
    input  logic [DIG_W-1:0]  auth_key,
    input  logic              erase_all,
    output logic              mem_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              hash_start,
    output logic              hash_valid,
    input  logic              hash_ready,
    output logic [WORD_W-1:0] hash_data,
    input  logic              hash_done,
    input  logic [DIG_W-1:0]  hash_digest,
    output logic              boot_release,
    output logic              hold_reset,
    output logic              busy
);
    localparam int                SEL_W    = $clog2(DIG_WORDS);
    localparam logic [ADDR_W-1:0] REF_SPAN = ADDR_W'(DIG_WORDS);
    localparam logic [ADDR_W-1:0] LAST_REF = ADDR_W'(DIG_WORDS - 1);

    seq_state_e        state, nxt;
    logic              fail_q, factory_q;
    logic [1:0]        opt_q;
    logic [ADDR_W-1:0] base_q, nwords_q;
    logic [DIG_W-1:0]  key_q;
    logic [1:0]        opt_eff;

    logic              cnt_clr, cnt_inc, ref_wr, fail_set, erase_take;
    logic [ADDR_W-1:0] cnt;
    logic              ref_match;
    logic              last_eight, data_last;

    // Factory configuration after a full erase means "no verification".
    assign opt_eff    = factory_q ? 2'd0 : boot_opt;
    assign last_eight = (cnt == LAST_REF);
    assign data_last  = (cnt == nwords_q - REF_SPAN - ADDR_W'(1));

    bsv_step_counter #(.W(ADDR_W)) u_cnt (
        .clk (clk),
        .clr (por | rst | cnt_clr),
        .inc (cnt_inc),
        .cnt (cnt)
    );

    bsv_ref_bank #(.NW(DIG_WORDS), .WW(WORD_W)) u_ref (
        .clk     (clk),
        .wr_en   (ref_wr),
        .wr_sel  (cnt[SEL_W-1:0]),
        .wr_word (mem_rdata),
        .digest  (hash_digest),
        .match   (ref_match)
    );

    always_comb begin
        nxt        = state;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        ref_wr     = 1'b0;
        fail_set   = 1'b0;
        erase_take = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (fail_q)                  nxt = ST_FAIL;
                else if (opt_checks(opt_eff)) nxt = ST_REF;
                else                         nxt = ST_PASS;
            end
            ST_REF: begin
                ref_wr = 1'b1;
                if (last_eight) begin
                    nxt     = ST_START;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_START: begin
                cnt_clr = 1'b1;
                nxt     = opt_keyed(opt_q) ? ST_KEY : ST_DATA;
            end
            ST_KEY: begin
                if (hash_ready) begin
                    if (last_eight) begin
                        nxt     = ST_DATA;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (hash_ready) begin
                    if (data_last) begin
                        nxt     = ST_WAIT;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (hash_done) begin
                    nxt      = ref_match ? ST_PASS : ST_FAIL;
                    fail_set = !ref_match;
                end
            end
            ST_PASS: nxt = ST_PASS;
            ST_FAIL: begin
                if (erase_all) begin
                    nxt        = ST_IDLE;
                    erase_take = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) begin
            state     <= ST_IDLE;
            fail_q    <= 1'b0;
            factory_q <= 1'b0;
            opt_q     <= 2'd0;
            base_q    <= '0;
            nwords_q  <= '0;
            key_q     <= '0;
        end else begin
            state <= rst ? ST_IDLE : nxt;
            if (!rst && fail_set) begin
                fail_q <= 1'b1;
            end else if (!rst && erase_take) begin
                fail_q    <= 1'b0;
                factory_q <= 1'b1;
            end
            if (!rst && state == ST_IDLE) begin
                opt_q    <= opt_eff;
                base_q   <= region_base;
                nwords_q <= region_words;
                key_q    <= auth_key;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_REF:  mem_addr = base_q + nwords_q - REF_SPAN + cnt;
            ST_DATA: mem_addr = base_q + cnt;
            default: mem_addr = base_q;
        endcase
    end

    assign mem_en       = (state == ST_REF) || (state == ST_DATA);
    assign hash_start   = (state == ST_START);
    assign hash_valid   = (state == ST_KEY) || (state == ST_DATA);
    assign hash_data    = (state == ST_KEY)  ? key_q[WORD_W*cnt[SEL_W-1:0] +: WORD_W] :
                          (state == ST_DATA) ? mem_rdata : '0;
    assign boot_release = (state == ST_PASS);
    assign hold_reset   = fail_q;
    assign busy         = (state != ST_PASS) && !fail_q;
endmodule

// File: rtl/bsv_checker.sv
module bsv_checker (
    input logic        clk,
    input logic        por,
    input logic        rst,
    input logic        erase_all,
    input logic        busy,
    input logic        boot_release,
    input logic        hold_reset,
    input logic        hash_start,
    input logic        hash_valid,
    input logic        hash_ready,
    input logic [31:0] hash_data
);
    // R11
    busy_fall_chk: assert property (@(posedge clk) disable iff (por || rst)
        $fell(busy) |-> (boot_release || hold_reset));

    // R7
    verdict_excl_chk: assert property (@(posedge clk) disable iff (por)
        !(boot_release && hold_reset));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (por || rst)
        (hash_valid && !hash_ready) |=> (hash_valid && $stable(hash_data)));

    // R8
    fail_sticky_chk: assert property (@(posedge clk) disable iff (por)
        (hold_reset && !erase_all) |=> hold_reset);

    // R6
    release_sticky_chk: assert property (@(posedge clk) disable iff (por || rst)
        boot_release |=> boot_release);

    // R3
    start_quiet_chk: assert property (@(posedge clk) disable iff (por || rst)
        hash_start |-> (!hash_valid && busy));

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (por || rst)
        hash_start |=> !hash_start);
endmodule

bind secure_boot_seq bsv_checker u_bsv_chk (
    .clk          (clk),
    .por          (por),
    .rst          (rst),
    .erase_all    (erase_all),
    .busy         (busy),
    .boot_release (boot_release),
    .hold_reset   (hold_reset),
    .hash_start   (hash_start),
    .hash_valid   (hash_valid),
    .hash_ready   (hash_ready),
    .hash_data    (hash_data)
);

// File: tb/secure_boot_seq_bench.sv
`timescale 1ns/1ps
module secure_boot_seq_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          por = 1'b1;
    logic          rst = 1'b1;
    logic [1:0]    boot_opt = 2'd0;
    logic [AW-1:0] region_base = '0;
    logic [AW-1:0] region_words = '0;
    logic [255:0]  auth_key = '0;
    logic          erase_all = 1'b0;
    logic          mem_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          hash_start, hash_valid;
    logic          hash_ready = 1'b0;
    logic [31:0]   hash_data;
    logic          hash_done = 1'b0;
    logic [255:0]  hash_digest = '0;
    logic          boot_release, hold_reset, busy;

    logic [31:0] mem [0:63];
    logic [31:0] exp_q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[5:0]];

    secure_boot_seq #(.ADDR_W(AW)) u_secure_boot_seq (
        .clk(clk), .por(por), .rst(rst), .boot_opt(boot_opt),
        .region_base(region_base), .region_words(region_words),
        .auth_key(auth_key), .erase_all(erase_all),
        .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .hash_start(hash_start), .hash_valid(hash_valid), .hash_ready(hash_ready),
        .hash_data(hash_data), .hash_done(hash_done), .hash_digest(hash_digest),
        .boot_release(boot_release), .hold_reset(hold_reset), .busy(busy)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL R11 watchdog cycles %0d expected below %0d", cyc, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Stub hash engine: a mixing function private to the bench.
    function automatic logic [255:0] model_digest();
        logic [31:0] acc [8];
        logic [255:0] packed_d;
        for (int j = 0; j < 8; j++) acc[j] = 32'h9e3779b9 * (j + 1);
        for (int k = 0; k < exp_q.size(); k++)
            acc[k % 8] = {acc[k % 8][26:0], acc[k % 8][31:27]} ^ exp_q[k] ^ 32'(k);
        for (int j = 0; j < 8; j++) packed_d[32*j +: 32] = acc[j];
        return packed_d;
    endfunction

    task automatic pulse_rst();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic run_case(input logic [1:0] opt, input int base, input int n,
                            input bit corrupt, input bit stall, input int erase_at);
        logic [255:0] dig;
        string        tag;
        int           beats;
        int           starts;
        bit           stalled;
        bit           send_done;
        logic [31:0]  held;
        tag = opt[1] ? "R4" : "R3";
        exp_q.delete();
        if (opt[1]) for (int i = 0; i < 8; i++) exp_q.push_back(auth_key[32*i +: 32]);
        for (int i = 0; i < n - 8; i++) begin
            mem[base + i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(base);
            if (opt != 2'd0) exp_q.push_back(mem[base + i]);
        end
        dig = model_digest();
        for (int j = 0; j < 8; j++)
            mem[base + n - 8 + j] = dig[32*j +: 32] ^ ((corrupt && j == 5) ? 32'h10 : 32'h0);
        boot_opt     = opt;
        region_base  = AW'(base);
        region_words = AW'(n);
        hash_ready   = 1'b0;
        pulse_rst();
        if (opt == 2'd0) begin
            @(negedge clk);
            chk(boot_release && !busy && !hold_reset, "R2 release after reset",
                {busy, boot_release}, 2'b01);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(!hash_start && boot_release, "R2 no hashing", hash_start, 0);
            end
            return;
        end
        beats = 0; starts = 0; stalled = 0; send_done = 0; held = '0;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            erase_all = (c == erase_at);
            if (send_done) begin
                hash_done   = 1'b1;
                hash_digest = dig;
                @(negedge clk);
                hash_done = 1'b0;
                erase_all = 1'b0;
                chk(starts == 1, $sformatf("%s single start", tag), starts, 1);
                if (corrupt)
                    chk(hold_reset && !boot_release && !busy, "R7 mismatch holds",
                        {busy, boot_release, hold_reset}, 3'b001);
                else
                    chk(boot_release && !hold_reset && !busy, "R6 match releases",
                        {busy, boot_release, hold_reset}, 3'b010);
                return;
            end
            chk(busy && !boot_release && !hold_reset, "R11 busy while verifying",
                {busy, boot_release, hold_reset}, 3'b100);
            if (hash_start) begin
                starts++;
                chk(beats == 0, $sformatf("%s start before data", tag), beats, 0);
            end
            if (stalled)
                chk(hash_valid && hash_data == held, "R5 stalled word held", hash_data, held);
            stalled    = 0;
            hash_ready = stall ? (c % 3 != 1) : 1'b1;
            if (hash_valid) begin
                if (hash_ready) begin
                    chk(hash_data == exp_q[beats], $sformatf("%s word %0d", tag, beats),
                        hash_data, exp_q[beats]);
                    beats++;
                    if (beats == exp_q.size()) send_done = 1;
                end else begin
                    stalled = 1;
                    held    = hash_data;
                end
            end
        end
        chk(0, "R11 run did not finish", beats, exp_q.size());
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) auth_key[32*i +: 32] = 32'hC0DE_0000 + 32'(i * 17);

        // R1: reset state under power-on reset
        @(negedge clk);
        chk(busy && !boot_release && !hold_reset, "R1 reset state",
            {busy, boot_release, hold_reset}, 3'b100);
        @(negedge clk);
        por = 1'b0;

        run_case(2'd0, 0, 12, 0, 0, -1);              // R2
        run_case(2'd1, 4, 20, 0, 0, 5);               // R3, R6, R10 erase mid-run
        run_case(2'd1, 10, 17, 0, 1, -1);             // R5 stalls
        run_case(2'd2, 30, 14, 0, 0, -1);             // R4
        run_case(2'd3, 40, 18, 0, 1, -1);             // R4 with stalls

        // R10: erase after release leaves the release in place
        @(negedge clk); erase_all = 1'b1;
        @(negedge clk); erase_all = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(boot_release && !hold_reset && !busy, "R10 erase ignored after release",
                {busy, boot_release, hold_reset}, 3'b010);
            @(negedge clk);
        end

        run_case(2'd1, 20, 16, 1, 0, -1);             // R7 mismatch

        // R8: failure survives warm reset, no new verification
        boot_opt = 2'd1;
        pulse_rst();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(hold_reset && !busy && !boot_release && !hash_start && !mem_en,
                "R8 failure sticky", {hold_reset, busy, boot_release, hash_start, mem_en},
                5'b10000);
        end

        // R9: full erase clears the failure and releases
        erase_all = 1'b1;
        @(negedge clk);
        erase_all = 1'b0;
        chk(!hold_reset && busy && !boot_release, "R9 hold cleared",
            {hold_reset, busy, boot_release}, 3'b010);
        @(negedge clk);
        chk(boot_release && !busy, "R9 release after erase", {boot_release, busy}, 2'b10);

        // R9: factory option persists across warm reset
        boot_opt = 2'd1;
        pulse_rst();
        @(negedge clk);
        chk(boot_release && !hash_start, "R9 factory skips verification",
            {boot_release, hash_start}, 2'b10);

        // R1: power-on reset clears factory state, verification returns
        por = 1'b1;
        @(negedge clk);
        chk(busy && !boot_release && !hold_reset, "R1 reset state after por",
            {busy, boot_release, hold_reset}, 3'b100);
        por = 1'b0;
        run_case(2'd1, 2, 24, 0, 0, -1);              // R1, R3 after por

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule